// File: doc/BRIEF.md
# Error Status Collector with NMI Escalation Watchdog

This block gathers single-cycle error event pulses from a set of sources (error aggregators among them) into a vector of sticky raw status bits. The same status vector can be written by software, so each bit can be forced on for testing. A separate write-one-to-clear address removes pending bits. An enable mask picks which status bits drive the non-maskable interrupt output. The output stays high while any enabled bit is pending.

While the interrupt is high, a high-priority watchdog counts clock cycles up to a programmable limit. If the pending error is not cleared in time, the watchdog sends out a single-cycle system reset request. If the interrupt drops, because the bits were cleared or masked off, the counter reloads. The next interrupt episode then gets the full timeout again.

Top module: `err_sig_top`

## Requirements
- R1: After reset the raw status and enable mask are zero, the timeout holds the parameter TMO_RST, and both the interrupt and the reset request outputs are low.
- R2: A high bit on `evt_i` in a cycle sets the matching raw status bit at that clock edge. A bit never becomes set without an event or a software set.
- R3: A register write to address 0 sets every raw status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R4: A register write to address 1 clears every raw status bit whose data bit is 1. If the same bit is set by an event or by an address-0 write in that cycle, the set wins and the bit stays 1.
- R5: `nmi_o` is high in the cycle after a clock edge exactly when the raw status ANDed with the enable mask (address 2) is non-zero.
- R6: With timeout T (address 3, low TMO_W bits), `rst_req_o` goes high for one cycle after the T-th consecutive clock edge at which `nmi_o` was high. A T of 0 behaves as 1.
- R7: Within one unbroken interrupt episode the reset request fires at most once. It is never high for two cycles in a row.
- R8: An edge at which `nmi_o` is low reloads the watchdog. A later episode waits a full T edges before its request.
- R9: `reg_rdata_o` combinationally returns the raw status for address 0 or 1, the enable mask for address 2, and the timeout for address 3, each zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | N_EVT | Error event pulses, one per status bit |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 set/raw, 1 clear, 2 enable, 3 timeout |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for `reg_addr_i` |
| nmi_o | output | 1 | Non-maskable interrupt |
| rst_req_o | output | 1 | Single-cycle reset request from the watchdog |

## Verification
Event pulses and register writes take effect at the next clock edge. Raw status, read data and `nmi_o` therefore reflect them one cycle later, and read data is also valid combinationally for the current address. The reset request comes from a register, so it is visible in the cycle after the T-th edge with the interrupt high. The bench drives inputs and samples outputs only on falling edges, and compares them with a model that it updates on rising edges. Directed cases count falling edges from the interrupt rise and expect the request at index T, to the cycle.

// File: rtl/err_sig_pkg.sv
package err_sig_pkg;
   typedef enum logic [1:0] {
      ADDR_RAW = 2'd0,
      ADDR_CLR = 2'd1,
      ADDR_EN  = 2'd2,
      ADDR_TMO = 2'd3
   } reg_addr_e;
endpackage

// File: rtl/err_sig_raw.sv
module err_sig_raw #(
   parameter int N_EVT = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] evt_i,
   input  logic [N_EVT-1:0] set_i,
   input  logic [N_EVT-1:0] clr_i,
   output logic [N_EVT-1:0] raw_o
);
   logic [N_EVT-1:0] raw_q;
   logic [N_EVT-1:0] any_set;

   assign any_set = evt_i | set_i;

   for (genvar b = 0; b < N_EVT; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            raw_q[b] <= 1'b0;
         else if (any_set[b])
            raw_q[b] <= 1'b1;
         else if (clr_i[b])
            raw_q[b] <= 1'b0;
      end
   end

   assign raw_o = raw_q;

   // R4
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (any_set != '0) |=> ((raw_q & $past(any_set)) == $past(any_set)));

   // R2
   no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((raw_q & ~$past(raw_q) & ~$past(any_set)) == '0));
endmodule

// File: rtl/err_sig_cfg.sv
module err_sig_cfg
   import err_sig_pkg::*;
#(
   parameter int          N_EVT   = 16,
   parameter int          TMO_W   = 16,
   parameter int          DATA_W  = 32,
   parameter logic [TMO_W-1:0] TMO_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [1:0]        addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [N_EVT-1:0]  set_o,
   output logic [N_EVT-1:0]  clr_o,
   output logic [N_EVT-1:0]  en_o,
   output logic [TMO_W-1:0]  tmo_o
);
   reg_addr_e        addr;
   logic [N_EVT-1:0] en_q;
   logic [TMO_W-1:0] tmo_q;

   assign addr  = reg_addr_e'(addr_i);
   assign set_o = (wr_i && addr == ADDR_RAW) ? wdata_i[N_EVT-1:0] : '0;
   assign clr_o = (wr_i && addr == ADDR_CLR) ? wdata_i[N_EVT-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         tmo_q <= TMO_RST;
      end else if (wr_i) begin
         if (addr == ADDR_EN)  en_q  <= wdata_i[N_EVT-1:0];
         if (addr == ADDR_TMO) tmo_q <= wdata_i[TMO_W-1:0];
      end
   end

   assign en_o  = en_q;
   assign tmo_o = tmo_q;
endmodule

// File: rtl/err_sig_wdog.sv
module err_sig_wdog #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             nmi_i,
   input  logic [TMO_W-1:0] tmo_i,
   output logic             rst_req_o
);
   localparam int CW = TMO_W + 1;

   logic [TMO_W-1:0] cnt_q;
   logic             fired_q;
   logic             req_q;
   logic             hit;

   assign hit = ({1'b0, cnt_q} + CW'(1)) >= {1'b0, tmo_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         fired_q <= 1'b0;
         req_q   <= 1'b0;
      end else begin
         req_q <= 1'b0;
         if (!nmi_i) begin
            cnt_q   <= '0;
            fired_q <= 1'b0;
         end else if (!fired_q) begin
            if (hit) begin
               req_q   <= 1'b1;
               fired_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign rst_req_o = req_q;

   // R7
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |=> !rst_req_o);

   // R6
   req_needs_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |-> $past(nmi_i));

   // R8
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !nmi_i |=> (cnt_q == '0 && !rst_req_o));
endmodule

// File: rtl/err_sig_top.sv
module err_sig_top
   import err_sig_pkg::*;
#(
   parameter int          N_EVT   = 16,
   parameter int          TMO_W   = 16,
   parameter int          DATA_W  = 32,
   parameter logic [TMO_W-1:0] TMO_RST = TMO_W'(1000)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_EVT-1:0]  evt_i,
   input  logic              reg_wr_i,
   input  logic [1:0]        reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              nmi_o,
   output logic              rst_req_o
);
   if (N_EVT < 1 || N_EVT > DATA_W) begin : g_bad_nevt
      $error("N_EVT must lie in 1..DATA_W");
   end
   if (TMO_W < 1 || TMO_W > DATA_W) begin : g_bad_tmow
      $error("TMO_W must lie in 1..DATA_W");
   end

   logic [N_EVT-1:0] set_w, clr_w, en_w, raw_w;
   logic [TMO_W-1:0] tmo_w;

   err_sig_cfg #(
      .N_EVT(N_EVT), .TMO_W(TMO_W), .DATA_W(DATA_W), .TMO_RST(TMO_RST)
   ) i_cfg (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
      .wdata_i(reg_wdata_i), .set_o(set_w), .clr_o(clr_w),
      .en_o(en_w), .tmo_o(tmo_w)
   );

   err_sig_raw #(.N_EVT(N_EVT)) i_raw (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .set_i(set_w),
      .clr_i(clr_w), .raw_o(raw_w)
   );

   assign nmi_o = |(raw_w & en_w);

   err_sig_wdog #(.TMO_W(TMO_W)) i_wdog (
      .clk(clk), .rst_n(rst_n), .nmi_i(nmi_o), .tmo_i(tmo_w),
      .rst_req_o(rst_req_o)
   );

   always_comb begin
      unique case (reg_addr_e'(reg_addr_i))
         ADDR_RAW, ADDR_CLR: reg_rdata_o = DATA_W'(raw_w);
         ADDR_EN:            reg_rdata_o = DATA_W'(en_w);
         default:            reg_rdata_o = DATA_W'(tmo_w);
      endcase
   end

   // R5
   nmi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_w == '0) |-> !nmi_o);
endmodule

// File: tb/test_err_sig_top.sv
module test_err_sig_top;
   localparam int N = 16;
   localparam int TW = 16;
   localparam int DW = 32;
   localparam logic [TW-1:0] TRST = TW'(1000);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  evt = '0;
   logic          wr = 1'b0;
   logic [1:0]    addr = 2'd0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          nmi, req;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   logic s_nmi, s_req;

   // model state
   logic [N-1:0]  m_raw, m_en;
   logic [TW-1:0] m_tmo, m_cnt;
   logic          m_fired, m_req;

   err_sig_top #(.N_EVT(N), .TMO_W(TW), .DATA_W(DW), .TMO_RST(TRST)) i_err_sig_top (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_wr_i(wr), .reg_addr_i(addr),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .nmi_o(nmi), .rst_req_o(req)
   );

   always #4 clk = ~clk;

   function automatic logic m_nmi();
      return |(m_raw & m_en);
   endfunction

   function automatic logic [DW-1:0] m_read(input logic [1:0] a);
      if (a <= 2'd1) return DW'(m_raw);
      if (a == 2'd2) return DW'(m_en);
      return DW'(m_tmo);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_raw <= '0; m_en <= '0; m_tmo <= TRST;
         m_cnt <= '0; m_fired <= 1'b0; m_req <= 1'b0;
      end else begin
         logic [N-1:0] st, cl;
         st = (wr && addr == 2'd0) ? wdata[N-1:0] : '0;
         cl = (wr && addr == 2'd1) ? wdata[N-1:0] : '0;
         m_raw <= (m_raw & ~cl) | st | evt;
         if (wr && addr == 2'd2) m_en <= wdata[N-1:0];
         if (wr && addr == 2'd3) m_tmo <= wdata[TW-1:0];
         m_req <= 1'b0;
         if (!m_nmi()) begin
            m_cnt <= '0; m_fired <= 1'b0;
         end else if (!m_fired) begin
            if (32'(m_cnt) + 1 >= 32'(m_tmo)) begin
               m_req <= 1'b1; m_fired <= 1'b1;
            end else m_cnt <= m_cnt + 1'b1;
         end
      end
   end

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic [N-1:0] e, input logic w, input logic [1:0] a,
                       input logic [DW-1:0] d);
      @(negedge clk);
      s_nmi = nmi; s_req = req;
      chk("R5 nmi vs model", DW'(nmi), DW'(m_nmi()));
      chk("R6 rst_req vs model", DW'(req), DW'(m_req));
      evt = e; wr = w; addr = a; wdata = d;
      #1;
      chk("R9 rdata vs model", rdata, m_read(a));
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step('0, 1'b0, 2'd0, '0);
   endtask

   initial begin
      while (cyc < 100000) begin
         @(posedge clk); cyc++;
      end
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1 nmi at reset", DW'(nmi), '0);
      chk("R1 rst_req at reset", DW'(req), '0);
      addr = 2'd0; #1 chk("R1 raw at reset", rdata, '0);
      addr = 2'd2; #1 chk("R1 enable at reset", rdata, '0);
      addr = 2'd3; #1 chk("R1 timeout at reset", rdata, DW'(TRST));
      rst_n = 1'b1;

      // R3: software set, zero bits do not clear
      step('0, 1'b1, 2'd0, DW'(16'h0005));
      step('0, 1'b1, 2'd0, DW'(16'h0000));
      step('0, 1'b0, 2'd0, '0);
      #1 chk("R3 zero write keeps bits", rdata, DW'(16'h0005));

      // R2: event pulse sets bit
      step(16'h0100, 1'b0, 2'd0, '0);
      step('0, 1'b0, 2'd0, '0);
      #1 chk("R2 event sets bit", rdata, DW'(16'h0105));

      // R4: clear with same-cycle event on bit 8: set wins, bit 0 clears
      step(16'h0100, 1'b1, 2'd1, DW'(16'h0101));
      step('0, 1'b0, 2'd1, '0);
      #1 chk("R4 set wins over clear", rdata, DW'(16'h0104));

      // R5: masked bits do not raise nmi
      step('0, 1'b1, 2'd2, DW'(16'h0002));
      step('0, 1'b0, 2'd0, '0);
      step('0, 1'b0, 2'd0, '0);
      chk("R5 masked raw gives no nmi", DW'(s_nmi), '0);

      // R6: timeout 5, enable bit 1, raise via event
      step('0, 1'b1, 2'd3, DW'(5));
      step(16'h0002, 1'b0, 2'd0, '0);
      for (int i = 0; i <= 5; i++) begin
         step('0, 1'b0, 2'd0, '0);
         chk("R6 request timing", DW'(s_req), DW'(i == 5));
      end
      // R7: no second request while nmi stays high
      for (int i = 0; i < 20; i++) begin
         step('0, 1'b0, 2'd0, '0);
         chk("R7 single request per episode", DW'(s_req), '0);
      end
      // R8: clear, reraise, full timeout again
      step('0, 1'b1, 2'd1, DW'(16'h0002));
      step('0, 1'b0, 2'd0, '0);
      chk("R8 nmi drops after clear", DW'(s_nmi), '0);
      step('0, 1'b1, 2'd0, DW'(16'h0002));
      for (int i = 0; i <= 5; i++) begin
         step('0, 1'b0, 2'd0, '0);
         chk("R8 reload gives full timeout", DW'(s_req), DW'(i == 5));
      end
      // R6: timeout 0 acts as 1
      step('0, 1'b1, 2'd1, DW'(16'hFFFF));
      step('0, 1'b1, 2'd3, DW'(0));
      step(16'h0002, 1'b0, 2'd0, '0);
      step('0, 1'b0, 2'd0, '0);
      chk("R6 timeout zero idx0", DW'(s_req), '0);
      step('0, 1'b0, 2'd0, '0);
      chk("R6 timeout zero idx1", DW'(s_req), 1);
      step('0, 1'b1, 2'd1, DW'(16'hFFFF));

      // random phase, checked against the model each cycle
      for (int k = 0; k < 4000; k++) begin
         logic [N-1:0] e;
         int op;
         e = ($urandom % 6 == 0) ? N'(1) << ($urandom % N) : '0;
         op = $urandom % 24;
         case (op)
            0:       step(e, 1'b1, 2'd0, DW'($urandom));
            1, 2, 3: step(e, 1'b1, 2'd1, DW'($urandom));
            4:       step(e, 1'b1, 2'd1, DW'(16'hFFFF));
            5:       step(e, 1'b1, 2'd2, DW'($urandom));
            6:       step(e, 1'b1, 2'd3, DW'($urandom % 12));
            default: step(e, 1'b0, 2'($urandom % 4), DW'($urandom));
         endcase
      end
      idle(4);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule